// File: doc/BRIEF.md
# Two-Stage Delay Decomposition Scheduler

This block is the electronic controller for a buffer built from two cascaded delay-line stages in a load-balanced switch. The first stage picks one of `B` lines whose delays are whole cycles of `N` slots (0, N, 2N, ... (B-1)N), or a discard line. The second stage picks one of `N` lines whose delays run from 0 to N-1 slots. Every total delay below B*N therefore splits in exactly one way into a cycle part `k` and a sub-cycle part `theta`.

The port count `N` must be a power of two and `B` must be at least 2. A free-running slot counter advances on each slot strobe. When a packet request arrives with a strobe, the block computes `theta` from the input port, the destination and the slot count. It then scans the candidate cycle delays from the smallest up. A candidate is usable only when both its first-stage exit slot and its final exit slot are free in two busy maps. The smallest usable candidate is granted and both of its slots are booked. If none is usable, the packet goes to the discard line. Both maps move one slot closer to the present on every strobe.

Top module: `dts_scheduler`

## Requirements
- R1: After reset the grant and drop outputs are low, `kdly_o` and `theta_o` are zero, the slot counter is zero and both busy maps are empty.
- R2: For a request with a slot strobe, `theta_o` equals (dst - src - t) mod N. Here t counts the slot strobes since reset, modulo N, and excludes the current one. The result appears one clock after the strobe.
- R3: A cycle delay k qualifies only when first-stage offset k*N and final offset k*N+theta are both free. Offset 0 of either map counts as free at all times.
- R4: Among the qualifying k in 0..B-1, the smallest is granted: `grant_o`=1, `drop_o`=0 and `kdly_o`=k, one clock after the strobe.
- R5: On a grant, first-stage offset k*N and final offset k*N+theta are both booked, and later requests see them as busy.
- R6: Each slot strobe moves every booking of both maps one offset closer, so offset j becomes offset j-1. A booking at offset 1 is dropped. The first-stage map spans offsets 1..(B-1)*N and the final map spans offsets 1..B*N-1.
- R7: When no k qualifies, the request is discarded: `drop_o`=1, `grant_o`=0, `kdly_o`=0, and neither map gains a booking.
- R8: A request without a slot strobe is ignored. The outputs are low one clock later, and neither the counter nor the maps change.
- R9: `grant_o` and `drop_o` are never high together. A cycle without a request that has a strobe leaves both low one clock later.
- R10: With N=4 and B=3, a request with theta=2 can find k=0 blocked at final offset 2 and k=1 blocked at final offset 6. In that case it is granted k=2, so it leaves the first stage 8 slots and the final stage 10 slots after arrival.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| slot_i | input | 1 | Slot strobe: advances the counter and both maps |
| req_i | input | 1 | Packet request, taken only together with `slot_i` |
| src_i | input | log2(N) | Input port of the packet |
| dst_i | input | log2(N) | Destination port of the packet |
| grant_o | output | 1 | Packet scheduled (registered) |
| drop_o | output | 1 | Packet sent to discard line (registered) |
| kdly_o | output | max(1,log2(B)) | Granted cycle delay k |
| theta_o | output | log2(N) | Sub-cycle delay theta |

## Verification
A hand-built chain of seven requests on empty maps steps through blocking in a fixed order. The first request takes k=0. A later one is pushed to k=1 by a final-map booking. The worked case is forced to k=2 by one final booking on each lower candidate. Next comes a discard in which every candidate is blocked, and after it a theta=0 request that only succeeds through the free offset 0. This chain separates an error in the pairing of the two maps from an error in shifting or in priority. Separate patterns fix the theta arithmetic over several port and counter phases and show that a request without a strobe changes nothing. A long pseudo-random stream with frequent strobes, dense requests and idle gaps then compares every outcome against a bench model of the two maps. This stream catches faults that only show up at map edges and in long booking chains.

// File: rtl/dts_pkg.sv
package dts_pkg;

    typedef enum logic [1:0] {
        RES_NONE  = 2'd0,
        RES_GRANT = 2'd1,
        RES_DROP  = 2'd2
    } res_e;

endpackage

// File: rtl/dts_theta.sv
// Sub-cycle delay: (dst - src - slot) modulo the power-of-two port count.
module dts_theta #(
    parameter int PW = 2
) (
    input  logic [PW-1:0] src_i,
    input  logic [PW-1:0] dst_i,
    input  logic [PW-1:0] cnt_i,
    output logic [PW-1:0] theta_o
);
    assign theta_o = dst_i - src_i - cnt_i;
endmodule

// File: rtl/dts_busy_map.sv
// Future-slot occupancy: bit i stands for offset i+1; offset 0 is not kept.
module dts_busy_map #(
    parameter int DEPTH = 8,
    parameter int OW    = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             shift_en,
    input  logic             set_en,
    input  logic [OW-1:0]    set_off,
    output logic [DEPTH-1:0] map_o
);
    logic [DEPTH-1:0] map_d, map_q, marked;

    always_comb begin
        marked = map_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (set_en && set_off == OW'(i + 1)) begin
                marked[i] = 1'b1;
            end
        end
        map_d = shift_en ? (marked >> 1) : marked;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            map_q <= '0;
        end else begin
            map_q <= map_d;
        end
    end

    assign map_o = map_q;
endmodule

// File: rtl/dts_pair_search.sv
// Checks B candidate pairs and picks the lowest cycle delay whose two slots are free.
module dts_pair_search #(
    parameter int N  = 4,
    parameter int B  = 3,
    parameter int L1 = (B - 1) * N,
    parameter int L2 = B * N - 1,
    parameter int PW = 2,
    parameter int KW = 2,
    parameter int OW = 4
) (
    input  logic [L1-1:0] map1_i,
    input  logic [L2-1:0] map2_i,
    input  logic [PW-1:0] theta_i,
    output logic          found_o,
    output logic [KW-1:0] k_o,
    output logic [OW-1:0] off1_o,
    output logic [OW-1:0] off2_o
);
    logic [L1:0]   ext1;
    logic [L2:0]   ext2;
    logic [B-1:0]  ok;

    // Offset 0 appended as a constant free position.
    assign ext1 = {map1_i, 1'b0};
    assign ext2 = {map2_i, 1'b0};

    for (genvar g = 0; g < B; g++) begin : g_cand
        localparam int BASE = g * N;
        logic [OW-1:0] off2;
        assign off2  = OW'(BASE) + OW'(theta_i);
        assign ok[g] = !ext1[BASE] && !ext2[off2];
    end

    always_comb begin
        found_o = 1'b0;
        k_o     = '0;
        off1_o  = '0;
        off2_o  = '0;
        for (int i = B - 1; i >= 0; i--) begin
            if (ok[i]) begin
                found_o = 1'b1;
                k_o     = KW'(i);
                off1_o  = OW'(i * N);
                off2_o  = OW'(i * N) + OW'(theta_i);
            end
        end
    end
endmodule

// File: rtl/dts_scheduler.sv
module dts_scheduler #(
    parameter int N = 4,
    parameter int B = 3,
    localparam int PW = $clog2(N),
    localparam int KW = (B > 2) ? $clog2(B) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          slot_i,
    input  logic          req_i,
    input  logic [PW-1:0] src_i,
    input  logic [PW-1:0] dst_i,
    output logic          grant_o,
    output logic          drop_o,
    output logic [KW-1:0] kdly_o,
    output logic [PW-1:0] theta_o
);
    import dts_pkg::*;

    localparam int L1 = (B - 1) * N;
    localparam int L2 = B * N - 1;
    localparam int OW = $clog2(L2 + 1);

    typedef struct packed {
        logic [PW-1:0] cnt;
        res_e          res;
        logic [KW-1:0] k;
        logic [PW-1:0] th;
    } state_t;

    state_t st_d, st_q;

    logic [PW-1:0] theta_w;
    logic [L1-1:0] map1_w;
    logic [L2-1:0] map2_w;
    logic          found_w;
    logic [KW-1:0] k_w;
    logic [OW-1:0] off1_w, off2_w;
    logic          book_w;

    dts_theta #(.PW(PW)) u_theta (
        .src_i   (src_i),
        .dst_i   (dst_i),
        .cnt_i   (st_q.cnt),
        .theta_o (theta_w)
    );

    dts_pair_search #(
        .N(N), .B(B), .L1(L1), .L2(L2), .PW(PW), .KW(KW), .OW(OW)
    ) u_search (
        .map1_i  (map1_w),
        .map2_i  (map2_w),
        .theta_i (theta_w),
        .found_o (found_w),
        .k_o     (k_w),
        .off1_o  (off1_w),
        .off2_o  (off2_w)
    );

    assign book_w = slot_i && req_i && found_w;

    dts_busy_map #(.DEPTH(L1), .OW(OW)) u_map_first (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (slot_i),
        .set_en   (book_w),
        .set_off  (off1_w),
        .map_o    (map1_w)
    );

    dts_busy_map #(.DEPTH(L2), .OW(OW)) u_map_final (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (slot_i),
        .set_en   (book_w),
        .set_off  (off2_w),
        .map_o    (map2_w)
    );

    always_comb begin
        st_d     = st_q;
        st_d.res = RES_NONE;
        st_d.k   = '0;
        st_d.th  = '0;
        if (slot_i) begin
            st_d.cnt = st_q.cnt + PW'(1);
            if (req_i) begin
                st_d.th = theta_w;
                if (found_w) begin
                    st_d.res = RES_GRANT;
                    st_d.k   = k_w;
                end else begin
                    st_d.res = RES_DROP;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{cnt: '0, res: RES_NONE, k: '0, th: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o = (st_q.res == RES_GRANT);
    assign drop_o  = (st_q.res == RES_DROP);
    assign kdly_o  = st_q.k;
    assign theta_o = st_q.th;
endmodule

// File: rtl/dts_scheduler_chk.sv
module dts_scheduler_chk #(
    parameter int N  = 4,
    parameter int B  = 3,
    parameter int PW = 2,
    parameter int KW = 2
) (
    input logic          clk,
    input logic          rst_n,
    input logic          slot_i,
    input logic          req_i,
    input logic [PW-1:0] src_i,
    input logic [PW-1:0] dst_i,
    input logic          grant_o,
    input logic          drop_o,
    input logic [KW-1:0] kdly_o,
    input logic [PW-1:0] theta_o
);
    logic [PW-1:0] slots_c;
    logic [PW-1:0] want_th;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            slots_c <= '0;
        end else if (slot_i) begin
            slots_c <= slots_c + PW'(1);
        end
    end

    assign want_th = dst_i - src_i - slots_c;

    AST_ONE_RESULT: assert property (@(posedge clk) disable iff (!rst_n)
        !(grant_o && drop_o)); // R9

    AST_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i && req_i) |=> (grant_o || drop_o)); // R7

    AST_NO_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !slot_i |=> (!grant_o && !drop_o)); // R8

    AST_THETA_SUM: assert property (@(posedge clk) disable iff (!rst_n)
        (slot_i && req_i) |=> (theta_o == $past(want_th))); // R2

    AST_K_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        grant_o |-> ({1'b0, kdly_o} < (KW + 1)'(B))); // R4

    AST_DROP_ZERO_K: assert property (@(posedge clk) disable iff (!rst_n)
        drop_o |-> (kdly_o == '0)); // R7
endmodule

bind dts_scheduler dts_scheduler_chk #(.N(N), .B(B), .PW(PW), .KW(KW)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .slot_i  (slot_i),
    .req_i   (req_i),
    .src_i   (src_i),
    .dst_i   (dst_i),
    .grant_o (grant_o),
    .drop_o  (drop_o),
    .kdly_o  (kdly_o),
    .theta_o (theta_o)
);

// File: tb/tb_dts_scheduler.sv
module tb_dts_scheduler;
    localparam int N  = 4;
    localparam int B  = 3;
    localparam int PW = 2;
    localparam int KW = 2;
    localparam int L1 = (B - 1) * N;
    localparam int L2 = B * N - 1;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          slot = 1'b0;
    logic          req = 1'b0;
    logic [PW-1:0] src = '0;
    logic [PW-1:0] dst = '0;
    logic          grant, drop;
    logic [KW-1:0] kdly;
    logic [PW-1:0] theta;

    int tests = 0;
    int fails = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dts_scheduler #(.N(N), .B(B)) dut (
        .clk(clk), .rst_n(rst_n), .slot_i(slot), .req_i(req),
        .src_i(src), .dst_i(dst), .grant_o(grant), .drop_o(drop),
        .kdly_o(kdly), .theta_o(theta)
    );

    typedef struct {
        bit    g;
        bit    dr;
        int    k;
        int    th;
        string tag;
    } exp_t;

    exp_t sb[$];

    // Bench model of the two busy maps (index = offset) and the slot count.
    bit m1 [0:L1];
    bit m2 [0:L2];
    int cnt = 0;

    task automatic check(input bit ok, input string tag, input string what);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: %s", tag, what);
        end
    endtask

    // Driver: one clock cycle of stimulus, expectation pushed to the scoreboard.
    task automatic cyc(input bit s, input bit rq, input int r, input int d,
                       input bit hand, input bit hg, input bit hd, input int hk,
                       input string tag);
        exp_t e;
        bit   ok;
        int   th;
        @(negedge clk);
        slot = s; req = rq; src = PW'(r); dst = PW'(d);
        e = '{g: 1'b0, dr: 1'b0, k: 0, th: 0, tag: tag};
        if (s && rq) begin
            th = (d - r - cnt) & (N - 1);
            e.th = th;
            ok = 1'b0;
            for (int kk = 0; kk < B; kk++) begin
                if (!ok && (kk == 0 || !m1[kk*N]) && ((kk*N + th) == 0 || !m2[kk*N + th])) begin
                    ok = 1'b1;
                    e.k = kk;
                end
            end
            if (ok) begin
                e.g = 1'b1;
                if (e.k * N > 0) m1[e.k * N] = 1'b1;
                if (e.k * N + th > 0) m2[e.k * N + th] = 1'b1;
            end else begin
                e.dr = 1'b1;
            end
            if (hand) begin
                e.g = hg; e.dr = hd; e.k = hk;
            end
        end
        if (s) begin
            for (int j = 1; j < L1; j++) m1[j] = m1[j+1];
            m1[L1] = 1'b0;
            for (int j = 1; j < L2; j++) m2[j] = m2[j+1];
            m2[L2] = 1'b0;
            cnt = (cnt + 1) % N;
        end
        sb.push_back(e);
    endtask

    task automatic req_th(input int r, input int th, input bit hg, input bit hd,
                          input int hk, input string tag);
        cyc(1'b1, 1'b1, r, (th + r + cnt) & (N - 1), 1'b1, hg, hd, hk, tag);
    endtask

    task automatic idle_slots(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 0, 0, 1'b0, 0, 0, 0, "R9");
    endtask

    // Monitor: compare registered outputs shortly after each rising edge.
    initial begin
        exp_t e;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                e = sb.pop_front();
                check(grant == e.g && drop == e.dr && int'(kdly) == e.k && int'(theta) == e.th,
                      e.tag,
                      $sformatf("got g=%0d d=%0d k=%0d th=%0d exp g=%0d d=%0d k=%0d th=%0d",
                                grant, drop, kdly, theta, e.g, e.dr, e.k, e.th));
            end
        end
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            fails++;
            tests++;
            $display("FAIL watchdog: run did not finish, actual=hung expected=done");
            $display("  [TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int j = 0; j <= L1; j++) m1[j] = 1'b0;
        for (int j = 0; j <= L2; j++) m2[j] = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the ports
        check(!grant && !drop && kdly == '0 && theta == '0, "R1",
              $sformatf("got g=%0d d=%0d k=%0d th=%0d exp all 0", grant, drop, kdly, theta));

        // R2: theta over several port, destination and counter phases
        cyc(1, 1, 0, 3, 0, 0, 0, 0, "R2");
        cyc(1, 1, 2, 1, 0, 0, 0, 0, "R2");
        cyc(1, 1, 3, 3, 0, 0, 0, 0, "R2");
        cyc(1, 1, 1, 0, 0, 0, 0, 0, "R2");
        idle_slots(L2 + 1);

        // R8: request without strobe ignored; counter and maps untouched
        cyc(0, 1, 1, 2, 1, 0, 0, 0, "R8");
        cyc(0, 1, 3, 0, 1, 0, 0, 0, "R8");
        cyc(1, 1, 1, 2, 0, 0, 0, 0, "R8");
        idle_slots(L2 + 1);

        // Directed chain: blocking, double booking, shifting, discard
        req_th(0, 2, 1, 0, 0, "R4");
        req_th(1, 1, 1, 0, 1, "R5");
        req_th(2, 3, 1, 0, 0, "R6");
        req_th(3, 3, 1, 0, 1, "R5");
        req_th(0, 2, 1, 0, 2, "R10");
        req_th(1, 1, 0, 1, 0, "R7");
        req_th(2, 0, 1, 0, 0, "R3");
        idle_slots(L2 + 1);

        // Pseudo-random stream against the map model
        for (int i = 0; i < 600; i++) begin
            cyc(($urandom % 10) < 8, ($urandom % 10) < 8,
                int'($urandom % N), int'($urandom % N), 0, 0, 0, 0, "R6");
        end
        cyc(0, 0, 0, 0, 0, 0, 0, 0, "R9");
        @(negedge clk);
        slot = 1'b0; req = 1'b0;
        while (sb.size() > 0) @(negedge clk);
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end
endmodule